// File: doc/BRIEF.md
# Preemptive Fixed-Priority Channel Arbiter

This block selects which of a set of DMA channels is serviced next. Each channel raises a service request and owns a software-written priority value and a preemption-enable bit. In fixed mode the pending channel with the largest priority value receives a registered one-hot grant. That grant is held until the active channel signals completion. The one exception is a preemptible channel: it yields to a higher-priority request and is marked as suspended until it wins again. In round-robin mode the priority values are ignored and grants rotate by channel index.

The priority table is checked continuously for repeated values. While any repeat exists, a configuration error is raised and the block starts no new grants and performs no preemption. In the low-power stop state, only the channels whose wake-enable bit is set take part in arbitration.

Top module: `dma_chan_arbiter`

## Requirements
- R1: After reset, channel i has priority i, no channel is preemptible, no grant or suspension is held, and the rotation pointer sits at the last channel. With channels 3 and 9 pending, channel 9 wins.
- R2: When no grant is held, the next clock edge grants the pending channel with the numerically largest priority. `grant_o` is one-hot, and `active_idx_o` gives its index.
- R3: A write on the configuration port (`cfg_we_i`) sets the priority and preemption bit of channel `cfg_ch_i` at the next clock edge.
- R4: `cfg_err_o` is 1 in the cycle after any two channels come to hold the same priority value. While it is 1, no grant starts and no preemption takes place.
- R5: An active channel whose preemption bit is 0 keeps the grant until `done_i`, whatever else is requested.
- R6: In fixed mode, an active preemptible channel hands the grant to a higher-priority pending channel at the next edge. Its bit in `suspended_o` is then set, and it is cleared when that channel is granted again.
- R7: `done_i` while a grant is held clears the grant at the next edge. One idle cycle precedes the next grant. If `done_i` and a preempting request arrive in the same cycle, the release wins and nothing is suspended.
- R8: With `rr_mode_i` = 1, grants go to the first pending channel in ascending index after the last granted one, wrapping around. Priorities are ignored and no preemption takes place.
- R9: With `stop_mode_i` = 1, a request counts only if that channel's `wake_en_i` bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | N_CH | Channel service requests, held until done |
| done_i | input | 1 | Active channel finished |
| rr_mode_i | input | 1 | 0 fixed priority, 1 round robin |
| stop_mode_i | input | 1 | System is in the low-power stop state |
| wake_en_i | input | N_CH | Per-channel request acceptance in stop state |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_ch_i | input | IDX_W | Channel being configured |
| cfg_pri_i | input | PRI_W | Priority value to write |
| cfg_pe_i | input | 1 | Preemption enable to write |
| grant_o | output | N_CH | One-hot registered grant |
| active_o | output | 1 | A grant is held |
| active_idx_o | output | IDX_W | Index of the granted channel |
| suspended_o | output | N_CH | Channels preempted and not yet resumed |
| cfg_err_o | output | 1 | Duplicate priority present |

## Verification
Completion and preemption can fall in the same cycle. This happens when a preemptible channel raises `done_i` on the same edge that a higher-priority request first appears. The bench drives both at one falling edge and then requires an empty grant with no suspended bit, followed by a grant to the newcomer one cycle later. A second overlap is a configuration write that creates a duplicate while a request waits. That case is judged by the grant staying empty until the table is repaired.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  typedef enum logic {
    ARB_FIXED = 1'b0,
    ARB_ROUND = 1'b1
  } arb_mode_e;
endpackage

// File: rtl/pri_dup_detect.sv
module pri_dup_detect #(
  parameter int unsigned N_CH  = 16,
  parameter int unsigned PRI_W = 4
) (
  input  logic [N_CH-1:0][PRI_W-1:0] pri_i,
  output logic                       dup_o
);
  logic [N_CH-1:0] hit;

  for (genvar i = 0; i < N_CH; i++) begin : g_row
    always_comb begin
      hit[i] = 1'b0;
      for (int j = i + 1; j < N_CH; j++) begin
        if (pri_i[i] == pri_i[j]) hit[i] = 1'b1;
      end
    end
  end

  assign dup_o = |hit;
endmodule

// File: rtl/prio_pick.sv
module prio_pick #(
  parameter int unsigned N_CH  = 16,
  parameter int unsigned PRI_W = 4,
  localparam int unsigned IDX_W = $clog2(N_CH)
) (
  input  logic [N_CH-1:0]            req_i,
  input  logic [N_CH-1:0][PRI_W-1:0] pri_i,
  output logic                       found_o,
  output logic [IDX_W-1:0]           idx_o
);
  logic [PRI_W-1:0] best;

  // ties (only possible with a bad table) resolve to the lowest index
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    best    = '0;
    for (int i = 0; i < N_CH; i++) begin
      if (req_i[i] && (!found_o || pri_i[i] > best)) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
        best    = pri_i[i];
      end
    end
  end
endmodule

// File: rtl/rr_pick.sv
module rr_pick #(
  parameter int unsigned N_CH = 16,
  localparam int unsigned IDX_W = $clog2(N_CH)
) (
  input  logic [N_CH-1:0]  req_i,
  input  logic [IDX_W-1:0] last_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int k = 1; k <= N_CH; k++) begin
      int unsigned c;
      c = (int'(last_i) + k) % N_CH;
      if (!found_o && req_i[c]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(c);
      end
    end
  end
endmodule

// File: rtl/dma_chan_arbiter.sv
module dma_chan_arbiter
  import dma_arb_pkg::*;
#(
  parameter int unsigned N_CH  = 16,
  parameter int unsigned PRI_W = 4,
  localparam int unsigned IDX_W = $clog2(N_CH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_CH-1:0]  req_i,
  input  logic             done_i,
  input  logic             rr_mode_i,
  input  logic             stop_mode_i,
  input  logic [N_CH-1:0]  wake_en_i,
  input  logic             cfg_we_i,
  input  logic [IDX_W-1:0] cfg_ch_i,
  input  logic [PRI_W-1:0] cfg_pri_i,
  input  logic             cfg_pe_i,
  output logic [N_CH-1:0]  grant_o,
  output logic             active_o,
  output logic [IDX_W-1:0] active_idx_o,
  output logic [N_CH-1:0]  suspended_o,
  output logic             cfg_err_o
);
  logic [N_CH-1:0][PRI_W-1:0] pri_q;
  logic [N_CH-1:0]            pe_q;
  logic [N_CH-1:0]            grant_q, grant_d, susp_q, susp_d;
  logic [IDX_W-1:0]           act_q, act_d, last_q, last_d;
  logic [N_CH-1:0]            eff_req;
  logic                       cfg_err, active;
  logic                       fx_found, rr_found;
  logic [IDX_W-1:0]           fx_idx, rr_idx;
  arb_mode_e                  mode;

  assign mode    = arb_mode_e'(rr_mode_i);
  assign eff_req = stop_mode_i ? (req_i & wake_en_i) : req_i;
  assign active  = |grant_q;

  // configuration table
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_CH; i++) pri_q[i] <= PRI_W'(i);
      pe_q <= '0;
    end else if (cfg_we_i) begin
      pri_q[cfg_ch_i] <= cfg_pri_i;
      pe_q[cfg_ch_i]  <= cfg_pe_i;
    end
  end

  pri_dup_detect #(.N_CH(N_CH), .PRI_W(PRI_W)) u_dup (
    .pri_i (pri_q),
    .dup_o (cfg_err)
  );

  prio_pick #(.N_CH(N_CH), .PRI_W(PRI_W)) u_fixed (
    .req_i   (eff_req),
    .pri_i   (pri_q),
    .found_o (fx_found),
    .idx_o   (fx_idx)
  );

  rr_pick #(.N_CH(N_CH)) u_rr (
    .req_i   (eff_req),
    .last_i  (last_q),
    .found_o (rr_found),
    .idx_o   (rr_idx)
  );

  always_comb begin
    grant_d = grant_q;
    act_d   = act_q;
    susp_d  = susp_q;
    last_d  = last_q;
    if (active) begin
      if (done_i) begin
        grant_d = '0;
      end else if (mode == ARB_FIXED && !cfg_err && pe_q[act_q] && fx_found &&
                   fx_idx != act_q && pri_q[fx_idx] > pri_q[act_q]) begin
        grant_d         = '0;
        grant_d[fx_idx] = 1'b1;
        susp_d[act_q]   = 1'b1;
        susp_d[fx_idx]  = 1'b0;
        act_d           = fx_idx;
      end
    end else if (!cfg_err) begin
      if (mode == ARB_ROUND) begin
        if (rr_found) begin
          grant_d         = '0;
          grant_d[rr_idx] = 1'b1;
          susp_d[rr_idx]  = 1'b0;
          act_d           = rr_idx;
          last_d          = rr_idx;
        end
      end else if (fx_found) begin
        grant_d         = '0;
        grant_d[fx_idx] = 1'b1;
        susp_d[fx_idx]  = 1'b0;
        act_d           = fx_idx;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grant_q <= '0;
      susp_q  <= '0;
      act_q   <= '0;
      last_q  <= IDX_W'(N_CH - 1);
    end else begin
      grant_q <= grant_d;
      susp_q  <= susp_d;
      act_q   <= act_d;
      last_q  <= last_d;
    end
  end

  assign grant_o      = grant_q;
  assign active_o     = active;
  assign active_idx_o = act_q;
  assign suspended_o  = susp_q;
  assign cfg_err_o    = cfg_err;

  assert_grant_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_q));

  assert_err_blocks_grant_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_err && !active) |=> (grant_q == '0));

  assert_no_preempt_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && !done_i && !pe_q[act_q]) |=> $stable(grant_q));

  assert_done_release_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && done_i) |=> (grant_q == '0));

  assert_rr_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && !done_i && rr_mode_i) |=> $stable(grant_q));
endmodule

// File: tb/dma_chan_arbiter_tb_top.sv
module dma_chan_arbiter_tb_top;
  localparam int N = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  req = '0;
  logic          done = 1'b0;
  logic          rr_mode = 1'b0;
  logic          stop_mode = 1'b0;
  logic [N-1:0]  wake_en = '0;
  logic          cfg_we = 1'b0;
  logic [3:0]    cfg_ch = '0;
  logic [3:0]    cfg_pri = '0;
  logic          cfg_pe = 1'b0;
  logic [N-1:0]  grant;
  logic          active;
  logic [3:0]    active_idx;
  logic [N-1:0]  suspended;
  logic          cfg_err;

  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  dma_chan_arbiter dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .done_i(done),
    .rr_mode_i(rr_mode), .stop_mode_i(stop_mode), .wake_en_i(wake_en),
    .cfg_we_i(cfg_we), .cfg_ch_i(cfg_ch), .cfg_pri_i(cfg_pri), .cfg_pe_i(cfg_pe),
    .grant_o(grant), .active_o(active), .active_idx_o(active_idx),
    .suspended_o(suspended), .cfg_err_o(cfg_err)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; req = '0; done = 1'b0; rr_mode = 1'b0; stop_mode = 1'b0;
    wake_en = '0; cfg_we = 1'b0;
    step(2);
    rst_n = 1'b1;
    step(1);
  endtask

  task automatic write_cfg(int ch, int pri, bit pe);
    cfg_we = 1'b1; cfg_ch = 4'(ch); cfg_pri = 4'(pri); cfg_pe = pe;
    step(1);
    cfg_we = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 grant after reset", 32'(grant), 0);
    check("R1 suspended after reset", 32'(suspended), 0);
    check("R1 cfg_err after reset", 32'(cfg_err), 0);
    req = (1 << 3) | (1 << 9);
    step(1);
    check("R1 default priority winner", 32'(grant), 32'(1 << 9));
    check("R1 active_idx", 32'(active_idx), 9);
  endtask

  task automatic t_fixed();
    do_reset();
    write_cfg(2, 15, 0);
    write_cfg(15, 2, 0);
    check("R3 table unique after swap", 32'(cfg_err), 0);
    req = (1 << 2) | (1 << 15) | (1 << 7);
    step(1);
    check("R2 highest programmed priority", 32'(grant), 32'(1 << 2));
    check("R2 active_o", 32'(active), 1);
    check("R2 active_idx", 32'(active_idx), 2);
  endtask

  task automatic t_dup();
    do_reset();
    write_cfg(0, 5, 0);
    check("R4 duplicate flagged", 32'(cfg_err), 1);
    req = 1 << 9;
    step(2);
    check("R4 no grant during error", 32'(grant), 0);
    write_cfg(0, 0, 0);
    check("R4 error cleared", 32'(cfg_err), 0);
    step(1);
    check("R4 grant after repair", 32'(grant), 32'(1 << 9));
  endtask

  task automatic t_nopreempt();
    do_reset();
    req = 1 << 1;
    step(1);
    check("R5 low channel granted", 32'(grant), 32'(1 << 1));
    req = (1 << 1) | (1 << 14);
    step(2);
    check("R5 not preempted", 32'(grant), 32'(1 << 1));
    done = 1'b1; req = 1 << 14;
    step(1);
    done = 1'b0;
    check("R7 release on done", 32'(grant), 0);
    step(1);
    check("R7 next grant after idle", 32'(grant), 32'(1 << 14));
  endtask

  task automatic t_preempt();
    do_reset();
    write_cfg(1, 1, 1);
    req = 1 << 1;
    step(1);
    check("R6 preemptible granted", 32'(grant), 32'(1 << 1));
    req = (1 << 1) | (1 << 14);
    step(1);
    check("R6 grant moved", 32'(grant), 32'(1 << 14));
    check("R6 suspended set", 32'(suspended), 32'(1 << 1));
    done = 1'b1; req = 1 << 1;
    step(1);
    done = 1'b0;
    check("R6 suspended held while idle", 32'(suspended), 32'(1 << 1));
    step(1);
    check("R6 resumed", 32'(grant), 32'(1 << 1));
    check("R6 suspended cleared", 32'(suspended), 0);
  endtask

  task automatic t_collide();
    do_reset();
    write_cfg(1, 1, 1);
    req = 1 << 1;
    step(1);
    req = 1 << 14; done = 1'b1;
    step(1);
    done = 1'b0;
    check("R7 done beats preemption grant", 32'(grant), 0);
    check("R7 done beats preemption suspend", 32'(suspended), 0);
    step(1);
    check("R7 newcomer granted", 32'(grant), 32'(1 << 14));
  endtask

  task automatic t_round();
    int exp_seq[4] = '{3, 9, 12, 3};
    do_reset();
    rr_mode = 1'b1;
    req = (1 << 3) | (1 << 9) | (1 << 12);
    step(1);
    check("R8 first rotation", 32'(grant), 32'(1 << exp_seq[0]));
    for (int k = 1; k < 4; k++) begin
      done = 1'b1;
      step(1);
      done = 1'b0;
      step(1);
      check("R8 rotation order", 32'(grant), 32'(1 << exp_seq[k]));
    end
  endtask

  task automatic t_stop();
    do_reset();
    stop_mode = 1'b1;
    wake_en = 1 << 4;
    req = (1 << 4) | (1 << 10);
    step(1);
    check("R9 masked channel skipped", 32'(grant), 32'(1 << 4));
    stop_mode = 1'b0; done = 1'b1; req = 1 << 10;
    step(1);
    done = 1'b0;
    step(1);
    check("R9 channel accepted after stop", 32'(grant), 32'(1 << 10));
  endtask

  initial begin
    t_reset();
    t_fixed();
    t_dup();
    t_nopreempt();
    t_preempt();
    t_collide();
    t_round();
    t_stop();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 20);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule